// File: doc/BRIEF.md
# Page Erase Command Sequencer

The sequencer takes a three-word erase command from a 16-bit valid/ready word stream. The first word holds an opcode and a length. The second word holds a page count and the top byte of a 24-bit start address. The third word holds the lower 16 address bits.

Once the third word is in, the block checks the frame, the page count and the page alignment of the start address. If all three are good, it walks the pages one at a time over a request/acknowledge memory port. The request stays raised, and the next page's address is presented after each acknowledge.

When the last page is acknowledged, a two-word status response leaves on a 16-bit valid/ready output stream. A rejected command produces a fail response and no memory request. The command input stays closed from the third word until the last response word has been taken.

Top module: `pgerase_seq`

## Requirements
- R1: After reset, cmd_ready is 1, mem_req is 0 and rsp_valid is 0.
- R2: A command is exactly three accepted words. Word 0 holds the opcode in bits 15:12 and the length in bits 11:0. Word 1 holds the page count in bits 15:8 and address bits 23:16 in bits 7:0. Word 2 holds address bits 15:0.
- R3: A valid command with page count N (1 to 255) produces exactly N acknowledged memory requests.
- R4: The first request carries the start address. Each following request carries the previous address plus 1024 (one page), wrapping modulo 2^24. While mem_ack is low, mem_req and mem_addr hold steady.
- R5: After the last page is acknowledged, the response is 0x1900 followed by 0x0002. No response word appears while a request is outstanding.
- R6: If start address bits 9:0 are not all zero, no request is issued. The response is 0x2900 then 0x0002.
- R7: A page count of zero issues no request and gives the response 0x2900 then 0x0002.
- R8: An opcode other than 0x9, or a length other than 3, issues no request. The response is {4'h2, received opcode, 8'h00} then 0x0002.
- R9: cmd_ready is 0 from the cycle after the third word is accepted until the cycle after the second response word is accepted.
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_data and rsp_valid hold steady.
- R11: A page count of 255 completes with 255 requests and a success response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_data | input | 16 | Command word |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word can be accepted |
| mem_req | output | 1 | Page erase request |
| mem_addr | output | 24 | Page address of the current request |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| rsp_data | output | 16 | Response word |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Downstream takes the response word |

## Verification
On the final page, two things share one clock edge: the acknowledge of the last request ends the page walk, and that same edge launches the status response. A checker property requires the success word to be on the output in the very next cycle. The bench provokes this with zero-delay and delayed acknowledges. It also compares its own request count against the expected page count at the moment the first response word appears, so a response that comes one page early, or a request that comes late, is caught. A wrapped address run and a 255-page run push the same coincidence through counter and address corners.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 8;

  localparam logic [3:0]        OPC_ERASE = 4'h9;
  localparam logic [11:0]       CMD_LEN   = 12'd3;
  localparam logic [3:0]        ST_OK     = 4'h1;
  localparam logic [3:0]        ST_FAIL   = 4'h2;
  localparam logic [WORD_W-1:0] RSP_LEN   = 16'h0002;

  typedef struct packed {
    logic [3:0]        opcode;
    logic [11:0]       len;
    logic [CNT_W-1:0]  pages;
    logic [ADDR_W-1:0] addr;
  } erase_cmd_t;

  // Split three raw words into command fields
  function automatic erase_cmd_t unpack_cmd(input logic [WORD_W-1:0] w0,
                                            input logic [WORD_W-1:0] w1,
                                            input logic [WORD_W-1:0] w2);
    erase_cmd_t c;
    c.opcode = w0[15:12];
    c.len    = w0[11:0];
    c.pages  = w1[15:8];
    c.addr   = {w1[7:0], w2};
    return c;
  endfunction

  function automatic logic page_aligned(input logic [ADDR_W-1:0] a,
                                        input int unsigned lg);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << lg) - ADDR_W'(1);
    return (a & mask) == '0;
  endfunction

  function automatic logic [ADDR_W-1:0] next_page(input logic [ADDR_W-1:0] a,
                                                  input int unsigned lg);
    return a + (ADDR_W'(1) << lg);
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic ok,
                                                    input logic [3:0] opc);
    return {ok ? ST_OK : ST_FAIL, opc, 8'h00};
  endfunction
endpackage

// File: rtl/pe_cmd_collect.sv
module pe_cmd_collect
  import pe_pkg::*;
#(
  parameter int NWORDS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WORD_W-1:0]             in_data,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          release_i,
  output logic [NWORDS-1:0][WORD_W-1:0] words_o,
  output logic                          full_o
);
  localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [IW-1:0] idx;
  logic          hold;
  logic          accept;
  logic          last_word;

  assign in_ready  = !hold;
  assign accept    = in_valid && in_ready;
  assign last_word = (idx == IW'(NWORDS - 1));

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          words_o[g] <= '0;
      else if (accept && idx == IW'(g))    words_o[g] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      hold   <= 1'b0;
      full_o <= 1'b0;
    end else begin
      full_o <= accept && last_word;
      if (accept) begin
        if (last_word) begin
          idx  <= '0;
          hold <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end else if (release_i) begin
        hold <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pe_page_walker.sv
module pe_page_walker
  import pe_pkg::*;
#(
  parameter int PAGE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_pages,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              page_ack_o,
  output logic              last_page_o,
  output logic              done_o
);
  logic              active;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;

  assign mem_req     = active;
  assign mem_addr    = addr_q;
  assign page_ack_o  = active && mem_ack;
  assign last_page_o = (left_q == CNT_W'(1));
  assign done_o      = page_ack_o && last_page_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      addr_q <= start_addr;
      left_q <= start_pages;
    end else if (page_ack_o) begin
      addr_q <= next_page(addr_q, PAGE_LOG2);
      left_q <= left_q - CNT_W'(1);
      if (last_page_o) active <= 1'b0;
    end
  end
endmodule

// File: rtl/pe_rsp_framer.sv
module pe_rsp_framer
  import pe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] status,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              done_o
);
  logic [WORD_W-1:0] stat_q;
  logic              second;
  logic              fire;

  assign fire     = out_valid && out_ready;
  assign out_data = second ? RSP_LEN : stat_q;
  assign done_o   = fire && second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      second    <= 1'b0;
      out_valid <= 1'b0;
    end else if (start) begin
      stat_q    <= status;
      second    <= 1'b0;
      out_valid <= 1'b1;
    end else if (fire) begin
      if (second) begin
        out_valid <= 1'b0;
        second    <= 1'b0;
      end else begin
        second <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgerase_seq.sv
module pgerase_seq
  import pe_pkg::*;
#(
  parameter int PAGE_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready
);
  localparam int NWORDS = 3;

  logic [NWORDS-1:0][WORD_W-1:0] words;
  erase_cmd_t                    cmd;
  logic                          cmd_full;
  logic                          frame_ok;
  logic                          args_ok;
  logic                          walk_go;
  logic                          reject;
  logic                          page_ack;
  logic                          last_page;
  logic                          walk_done;
  logic                          rsp_launch;
  logic                          rsp_done;
  logic [WORD_W-1:0]             launch_word;

  assign cmd      = unpack_cmd(words[0], words[1], words[2]);
  assign frame_ok = (cmd.opcode == OPC_ERASE) && (cmd.len == CMD_LEN);
  assign args_ok  = (cmd.pages != '0) && page_aligned(cmd.addr, PAGE_LOG2);
  assign walk_go  = cmd_full && frame_ok && args_ok;
  assign reject   = cmd_full && !(frame_ok && args_ok);

  assign rsp_launch  = reject || walk_done;
  assign launch_word = status_word(!reject, cmd.opcode);

  pe_cmd_collect #(.NWORDS(NWORDS)) i_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (cmd_data),
    .in_valid (cmd_valid),
    .in_ready (cmd_ready),
    .release_i(rsp_done),
    .words_o  (words),
    .full_o   (cmd_full)
  );

  pe_page_walker #(.PAGE_LOG2(PAGE_LOG2)) i_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (walk_go),
    .start_addr (cmd.addr),
    .start_pages(cmd.pages),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .page_ack_o (page_ack),
    .last_page_o(last_page),
    .done_o     (walk_done)
  );

  pe_rsp_framer i_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rsp_launch),
    .status   (launch_word),
    .out_data (rsp_data),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .done_o   (rsp_done)
  );
endmodule

// File: rtl/pgerase_seq_chk.sv
module pgerase_seq_chk
  import pe_pkg::*;
#(
  parameter int PAGE_LOG2 = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [WORD_W-1:0] rsp_data,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              page_ack,
  input logic              last_page
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << PAGE_LOG2;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> cmd_ready && !mem_req && !rsp_valid);

  assert_req_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_addr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    page_ack && !last_page |=> mem_req && mem_addr == $past(mem_addr) + STEP);

  assert_req_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[PAGE_LOG2-1:0] == '0);

  assert_last_launches_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    page_ack && last_page |=> rsp_valid && rsp_data == 16'h1900);

  assert_no_rsp_during_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req);

  assert_closed_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || rsp_valid) |-> !cmd_ready);

  assert_rsp_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

bind pgerase_seq pgerase_seq_chk #(.PAGE_LOG2(PAGE_LOG2)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .rsp_data (rsp_data),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .page_ack (page_ack),
  .last_page(last_page)
);

// File: tb/test_pgerase_seq.sv
`timescale 1ns/1ps
module test_pgerase_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  // responder state
  logic [23:0] exp_base = '0;
  int          req_seen = 0;
  int          ack_delay = 0;
  int          wait_cnt = 0;

  always #2.5 clk = ~clk;

  pgerase_seq i_pgerase_seq (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Memory responder: acknowledges after ack_delay idle cycles, checks address (R4)
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wait_cnt >= ack_delay) begin
          logic [23:0] e;
          e = exp_base + (24'(req_seen) << 10);
          chk("R4", "request address", {8'h0, mem_addr}, {8'h0, e});
          req_seen++;
          mem_ack  = 1'b1;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic send_word(input logic [15:0] w);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input logic [15:0] exp0,
                         input int exp_pages, input int delay, input int stall,
                         input string tag);
    bit busy_bad = 0;
    bit stall_bad = 0;
    int n = 0;
    exp_base  = {w1[7:0], w2};
    req_seen  = 0;
    ack_delay = delay;
    wait_cnt  = 0;
    send_word(w0);
    send_word(w1);
    send_word(w2);
    // R9: input stays closed while the command is being served
    while (!rsp_valid && n < 5000) begin
      if (cmd_ready) busy_bad = 1;
      @(negedge clk);
      n++;
    end
    chk("R3", {tag, " requests before response"}, 32'(req_seen), 32'(exp_pages));
    for (int s = 0; s < stall; s++) begin
      if (!rsp_valid || rsp_data !== exp0 || cmd_ready) stall_bad = 1;
      @(negedge clk);
    end
    if (stall > 0) chk("R10", {tag, " held under backpressure"}, 32'(stall_bad), 32'd0);
    chk(tag, "response word 0", {15'h0, rsp_valid, rsp_data}, {15'h0, 1'b1, exp0});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (cmd_ready) busy_bad = 1;
    chk(tag, "response word 1", {15'h0, rsp_valid, rsp_data}, {15'h0, 1'b1, 16'h0002});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9", {tag, " busy window"}, 32'(busy_bad), 32'd0);
    chk("R9", {tag, " reopened"}, {30'h0, cmd_ready, rsp_valid}, {30'h0, 2'b10});
    chk("R3", {tag, " no extra request"}, 32'(req_seen), 32'(exp_pages));
  endtask

  // w0, w1, w2, expected first response word, expected pages
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {16'h9003, 16'h0112, 16'h3400, 16'h1900, 8'd1},
    {16'h9003, 16'h0400, 16'h0000, 16'h1900, 8'd4},
    {16'h9003, 16'h03FF, 16'hFC00, 16'h1900, 8'd3},
    {16'h9003, 16'h0512, 16'h3480, 16'h2900, 8'd0},
    {16'h9003, 16'h0012, 16'h3400, 16'h2900, 8'd0},
    {16'h5003, 16'h0212, 16'h3400, 16'h2500, 8'd0},
    {16'h9004, 16'h0212, 16'h3400, 16'h2900, 8'd0},
    {16'h9002, 16'h0212, 16'h3400, 16'h2900, 8'd0}
  };
  string tags [NV] = '{"R2", "R5", "R4", "R6", "R7", "R8", "R8", "R8"};

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle state out of reset
    chk("R1", "reset idle", {29'h0, cmd_ready, mem_req, rsp_valid}, {29'h0, 3'b100});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", {29'h0, cmd_ready, mem_req, rsp_valid}, {29'h0, 3'b100});

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i][71:56], VEC[i][55:40], VEC[i][39:24], VEC[i][23:8],
              int'(VEC[i][7:0]), i % 3, 0, tags[i]);
    end

    // R6: only bit 9 set is still misaligned
    run_cmd(16'h9003, 16'h0200, 16'h0200, 16'h2900, 0, 0, 0, "R6");
    // R10: backpressure on a success response
    run_cmd(16'h9003, 16'h0220, 16'h0800, 16'h1900, 2, 2, 4, "R10");
    // R5: zero-delay acknowledges, last ack and launch coincide
    run_cmd(16'h9003, 16'h0600, 16'h4000, 16'h1900, 6, 0, 1, "R5");
    // R11: maximum page count
    run_cmd(16'h9003, 16'hFF00, 16'h0000, 16'h1900, 255, 1, 0, "R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule